// File: doc/BRIEF.md
# Dual-Processor Bus Handover Controller

This block decides which of two processors, A and B, owns a shared system bus and the system clock. A select input asks for a processor. When the request differs from the current owner, the block stops the outgoing processor's system clock and puts both processors in hold. It waits until both have acknowledged the hold, and only then makes the incoming processor the owner. It releases the incoming processor's hold on that processor's next clock edge. It passes the incoming processor's clock to the system on a later edge of that same clock.

The block runs on one fast controller clock. Each processor clock appears as a one-cycle tick input that marks that processor's rising clock edge. The select input is asynchronous. It passes through a chain of flip-flops before the sequencer uses it. A handover always runs to completion. If the select input changes again during a handover, the request is acted on after the current handover ends.

Top module: `dcs_switchover`

## Requirements
- R1: After reset, A owns the bus: `hold_a_o`=0, `hold_b_o`=1, `sysclk_en_a_o`=1, `sysclk_en_b_o`=0 and `b_active_o`=0.
- R2: `sel_b_i` (1 selects B, 0 selects A) passes through SYNC_STAGES flip-flops. With the default of 2, a change applied before clock edge 1 first affects the outputs after edge 3.
- R3: A handover starts when the synchronized select differs from the owner. In that same cycle, both hold outputs go high and the outgoing processor's clock enable goes low.
- R4: The two clock enables are never high together. Both stay low from the start of a handover until the incoming gate opens.
- R5: Ownership passes to the incoming processor only after a cycle in which both hold-acknowledges are high. Its hold output then falls on the first incoming tick after that cycle, and never earlier.
- R6: The incoming clock enable rises on the first incoming tick after the tick that released its hold.
- R7: `bus_hlda_o` is high exactly when `hlda_a_i` and `hlda_b_i` are both high.
- R8: `b_active_o` is high exactly when B owns the bus and `hold_b_o` is low. It rises in the same cycle that `hold_b_o` falls.
- R9: While one processor is active, the other processor's hold output stays high.
- R10: A handover from B back to A follows the same sequence, with the roles of the two processors swapped.
- R11: If the select input changes during a handover, the handover still completes. The new request is then served by a further handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_b_i | input | 1 | Asynchronous select, 1 requests processor B |
| tick_a_i | input | 1 | One-cycle pulse marking a rising edge of processor A's clock |
| tick_b_i | input | 1 | One-cycle pulse marking a rising edge of processor B's clock |
| hlda_a_i | input | 1 | Hold-acknowledge from processor A |
| hlda_b_i | input | 1 | Hold-acknowledge from processor B |
| hold_a_o | output | 1 | Hold request to processor A |
| hold_b_o | output | 1 | Hold request to processor B |
| bus_hlda_o | output | 1 | Combined bus hold-acknowledge |
| sysclk_en_a_o | output | 1 | Passes processor A's clock to the system |
| sysclk_en_b_o | output | 1 | Passes processor B's clock to the system |
| b_active_o | output | 1 | High while processor B is the running owner |

## Verification
The bench builds the block with the default SYNC_STAGES of 2, so the three-edge delay from select to hold can be measured exactly. The bench changes the tick periods and the acknowledge latency of each processor between scenarios. This moves the release and clock-open edges relative to the acknowledge cycle, and exercises both the case where an incoming tick is waited for and the case where a tick arrives at once. A select reversal placed inside a handover covers the case where a handover must complete before the next one starts.

// File: rtl/dcs_pkg.sv
// Package: shared types and constants of the switchover controller.
// Assumes exactly two processors, indexed 0 (A) and 1 (B).
package dcs_pkg;
    localparam int NUM_CPU = 2;
    localparam int CPU_A   = 0;
    localparam int CPU_B   = 1;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,  // owner running with its clock passed
        ST_QUIESCE = 2'd1,  // both held, waiting for both acknowledges
        ST_RELEASE = 2'd2,  // new owner chosen, waiting for its tick
        ST_CLKON   = 2'd3   // hold released, waiting for tick to open gate
    } dcs_state_e;
endpackage

// File: rtl/dcs_sync.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2; the output lags the input by STAGES edges.
module dcs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the input level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dcs_hold_latch.sv
// Module: hold-request latch for one processor.
// A force input sets it; a release strobe clears it. Force wins over release.
module dcs_hold_latch #(
    parameter bit RESET_HELD = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_i,
    input  logic release_i,
    output logic hold_o
);
    // Keep the hold until an explicit release arrives without a force.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_o <= RESET_HELD;
        else if (force_i)   hold_o <= 1'b1;
        else if (release_i) hold_o <= 1'b0;
    end
endmodule

// File: rtl/dcs_clk_gate.sv
// Module: registered enable that passes one processor clock to the system.
// Close has priority over open; the enable changes only on controller edges.
module dcs_clk_gate #(
    parameter bit RESET_OPEN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic close_i,
    input  logic open_i,
    output logic en_o
);
    // Track the gate state from close and open strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_o <= RESET_OPEN;
        else if (close_i) en_o <= 1'b0;
        else if (open_i)  en_o <= 1'b1;
    end
endmodule

// File: rtl/dcs_switchover.sv
// Module: break-before-make handover of a shared bus between two processors.
// Assumes the tick inputs are one controller cycle wide and synchronous to clk,
// and that each processor holds its acknowledge while its hold request is high.
module dcs_switchover #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_b_i,
    input  logic tick_a_i,
    input  logic tick_b_i,
    input  logic hlda_a_i,
    input  logic hlda_b_i,
    output logic hold_a_o,
    output logic hold_b_o,
    output logic bus_hlda_o,
    output logic sysclk_en_a_o,
    output logic sysclk_en_b_o,
    output logic b_active_o
);
    import dcs_pkg::*;

    dcs_state_e         st_q, st_d;
    logic               owner_b_q, owner_b_d;
    logic               req_b;
    logic               mismatch;
    logic [NUM_CPU-1:0] tick, hold, en, release_v, open_v, close_v;

    assign tick = {tick_b_i, tick_a_i};

    dcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sel_b_i), .q_o(req_b)
    );

    // A request differing from the owner starts a handover while running.
    assign mismatch = (st_q == ST_RUN) && (req_b != owner_b_q);

    // Sequencer: quiesce, choose owner, release hold, then open the clock.
    always_comb begin
        st_d      = st_q;
        owner_b_d = owner_b_q;
        unique case (st_q)
            ST_RUN:     if (mismatch) st_d = ST_QUIESCE;
            ST_QUIESCE: if (hlda_a_i && hlda_b_i) begin
                            owner_b_d = ~owner_b_q;
                            st_d      = ST_RELEASE;
                        end
            ST_RELEASE: if (tick[owner_b_q]) st_d = ST_CLKON;
            ST_CLKON:   if (tick[owner_b_q]) st_d = ST_RUN;
            default:    st_d = ST_RUN;
        endcase
    end

    // Hold the sequencer state and the current owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_RUN;
            owner_b_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            owner_b_q <= owner_b_d;
        end
    end

    // One hold latch and one clock gate per processor.
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        localparam bit IS_B = (i == CPU_B);
        assign release_v[i] = (st_q == ST_RELEASE) && (owner_b_q == IS_B) && tick[i];
        assign open_v[i]    = (st_q == ST_CLKON)   && (owner_b_q == IS_B) && tick[i];
        assign close_v[i]   = mismatch && (owner_b_q == IS_B);

        dcs_hold_latch #(.RESET_HELD(IS_B)) u_hold (
            .clk(clk), .rst_n(rst_n), .force_i(mismatch),
            .release_i(release_v[i]), .hold_o(hold[i])
        );

        dcs_clk_gate #(.RESET_OPEN(!IS_B)) u_gate (
            .clk(clk), .rst_n(rst_n), .close_i(close_v[i]),
            .open_i(open_v[i]), .en_o(en[i])
        );
    end

    assign hold_a_o      = hold[CPU_A];
    assign hold_b_o      = hold[CPU_B];
    assign sysclk_en_a_o = en[CPU_A];
    assign sysclk_en_b_o = en[CPU_B];
    assign bus_hlda_o    = hlda_a_i && hlda_b_i;
    assign b_active_o    = owner_b_q && !hold[CPU_B];
endmodule

// File: rtl/dcs_switchover_chk.sv
// Module: protocol checker for the switchover controller, bound to its top.
// Assumes synchronous active-low reset on rst_n.
module dcs_switchover_chk (
    input logic clk,
    input logic rst_n,
    input logic hlda_a_i,
    input logic hlda_b_i,
    input logic hold_a_o,
    input logic hold_b_o,
    input logic sysclk_en_a_o,
    input logic sysclk_en_b_o,
    input logic b_active_o
);
    logic acked_q;

    // Remember a cycle with both processors held and acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)                                             acked_q <= 1'b0;
        else if (hold_a_o && hold_b_o && hlda_a_i && hlda_b_i) acked_q <= 1'b1;
        else if (!hold_a_o || !hold_b_o)                       acked_q <= 1'b0;
    end

    a_r4_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sysclk_en_a_o && sysclk_en_b_o));

    a_r5_release_b_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_b_o) |-> acked_q);

    a_r5_release_a_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_a_o) |-> acked_q);

    a_r3_close_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sysclk_en_a_o) || $fell(sysclk_en_b_o)) |-> (hold_a_o && hold_b_o));

    a_r6_open_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysclk_en_b_o) |-> (!hold_b_o && $past(!hold_b_o)));

    a_r9_outgoing_held: assert property (@(posedge clk) disable iff (!rst_n)
        b_active_o |-> hold_a_o);
endmodule

bind dcs_switchover dcs_switchover_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hlda_a_i(hlda_a_i), .hlda_b_i(hlda_b_i),
    .hold_a_o(hold_a_o), .hold_b_o(hold_b_o),
    .sysclk_en_a_o(sysclk_en_a_o), .sysclk_en_b_o(sysclk_en_b_o),
    .b_active_o(b_active_o)
);

// File: tb/tb_dcs_switchover.sv
// Bench: behavioural per-cycle model of the handover, compared every cycle.
module tb_dcs_switchover;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_b = 1'b0;
    logic tick_a = 1'b0, tick_b = 1'b0;
    logic hlda_a = 1'b0, hlda_b = 1'b0;
    logic hold_a, hold_b, bus_hlda, en_a, en_b, b_act;

    int vectors = 0, misses = 0, cyc = 0;
    int per_a = 3, per_b = 5, lat_a = 2, lat_b = 2;
    int cnt_a = 0, cnt_b = 0, ack_a = 0, ack_b = 0;

    // Reference model state.
    bit q_sync[$];
    int m_phase, m_owner;
    bit m_hold[2], m_en[2];

    always #2 clk = ~clk;

    dcs_switchover #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .sel_b_i(sel_b), .tick_a_i(tick_a),
        .tick_b_i(tick_b), .hlda_a_i(hlda_a), .hlda_b_i(hlda_b),
        .hold_a_o(hold_a), .hold_b_o(hold_b), .bus_hlda_o(bus_hlda),
        .sysclk_en_a_o(sysclk_en_a), .sysclk_en_b_o(sysclk_en_b),
        .b_active_o(b_act)
    );
    logic sysclk_en_a, sysclk_en_b;
    assign en_a = sysclk_en_a;
    assign en_b = sysclk_en_b;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Reference model: advance on each controller edge from the applied inputs.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q_sync = {};
            for (int k = 0; k < SYNC; k++) q_sync.push_back(1'b0);
            m_phase = 0; m_owner = 0;
            m_hold[0] = 0; m_hold[1] = 1; m_en[0] = 1; m_en[1] = 0;
        end else begin
            bit req;
            bit tk[2];
            req = q_sync[SYNC-1];
            tk[0] = tick_a; tk[1] = tick_b;
            case (m_phase)
                0: if (int'(req) != m_owner) begin
                       m_hold[0] = 1; m_hold[1] = 1; m_en[m_owner] = 0; m_phase = 1;
                   end
                1: if (hlda_a && hlda_b) begin m_owner = 1 - m_owner; m_phase = 2; end
                2: if (tk[m_owner]) begin m_hold[m_owner] = 0; m_phase = 3; end
                default: if (tk[m_owner]) begin m_en[m_owner] = 1; m_phase = 0; end
            endcase
            void'(q_sync.pop_back());
            q_sync.push_front(sel_b);
        end
        if (cyc == 100000) begin
            misses++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    // Compare, then drive processor behaviour, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3/R9", "hold_a", hold_a, m_hold[0]);
            chk("R3/R9", "hold_b", hold_b, m_hold[1]);
            chk("R6", "en_a", en_a, m_en[0]);
            chk("R6", "en_b", en_b, m_en[1]);
            chk("R4", "exclusive", en_a && en_b, 0);
            chk("R7", "bus_hlda", bus_hlda, hlda_a && hlda_b);
            chk("R8", "b_active", b_act, (m_owner == 1) && !m_hold[1]);
        end
        ack_a = hold_a ? ack_a + 1 : 0;
        ack_b = hold_b ? ack_b + 1 : 0;
        hlda_a <= hold_a && (ack_a >= lat_a);
        hlda_b <= hold_b && (ack_b >= lat_b);
        cnt_a = (cnt_a + 1) % per_a;
        cnt_b = (cnt_b + 1) % per_b;
        tick_a <= (cnt_a == 0);
        tick_b <= (cnt_b == 0);
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset hold_a", hold_a, 0);
        chk("R1", "reset hold_b", hold_b, 1);
        chk("R1", "reset en_a", en_a, 1);
        chk("R1", "reset en_b", en_b, 0);
        chk("R1", "reset b_active", b_act, 0);
        settle(8);

        // A to B: measure synchronizer latency.
        sel_b = 1'b1;
        n = 0;
        while (!hold_a && n < 20) begin @(negedge clk); n++; end
        chk("R2", "edges to hold", n, SYNC + 1);
        settle(40);
        chk("R5", "B owns after handover", b_act, 1);
        chk("R9", "A held while B runs", hold_a, 1);

        // B back to A with other periods.
        per_a = 7; per_b = 2; lat_a = 5; lat_b = 1;
        sel_b = 1'b0;
        settle(60);
        chk("R10", "A enable back", en_a, 1);
        chk("R10", "B held again", hold_b, 1);

        // Reversal inside a handover.
        per_a = 4; per_b = 6; lat_a = 3; lat_b = 4;
        sel_b = 1'b1;
        settle(5);
        sel_b = 1'b0;
        settle(8);
        chk("R11", "handover continues", en_a, 0);
        settle(100);
        chk("R11", "back to A", en_a, 1);
        chk("R11", "B inactive", b_act, 0);

        // Immediate ticks and long acknowledge.
        per_a = 1; per_b = 1; lat_a = 9; lat_b = 0;
        sel_b = 1'b1;
        settle(40);
        chk("R6", "B clock on", en_b, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule